// File: doc/BRIEF.md
# PWM Channel with Left and Center Alignment

This block is a single pulse-width-modulation channel. A surrounding clock generator supplies thirteen single-cycle enable strobes on a shared system clock. Eleven of them are power-of-two divisions of the master clock; strobe 0 is the undivided clock and is high every cycle. The last two are the outputs of two programmable dividers. A 4-bit select picks one strobe, and a 16-bit counter advances only on that strobe.

In left-aligned mode the counter climbs from zero and wraps at the period setting. In center-aligned mode it climbs to the period setting and then descends back to zero, so each period is twice as long. A comparator drives the output pin from the counter and the duty setting. A one-cycle event marks the end of every period.

Period, duty, alignment and polarity are held in working copies. These copies reload only at a period boundary, or on every cycle while the channel is disabled, so a new setting never produces a shortened or glitched cycle. The block has no data stream, so it has no valid/ready interface. All of its pins are plain control and status levels.

Top module: `pwm_chan`

## Requirements
- R1: `cfg_sel` values 0 to 12 make `src_tick[cfg_sel]` the counter's advance strobe. Values 13 to 15 select no strobe, and the counter freezes.
- R2: While `en` is high, the counter changes only in cycles where the selected strobe is high.
- R3: Left-aligned mode (`cfg_center`=0), working period P≥1: the counter steps 0,1,…,P−1 and then returns to 0, so a period lasts P strobes. With P=0 every strobe ends a period.
- R4: Center-aligned mode (`cfg_center`=1), working period P≥1: the counter steps 0,1,…,P, then P−1,…,1, and then returns to 0, so a period lasts 2P strobes. With P=0 every strobe ends a period.
- R5: `period_end` is high for exactly one cycle. That cycle follows the clock edge at which the counter returned to 0 at a boundary.
- R6: While enabled, `pwm_out` equals the working polarity while the counter is below the working duty, and its inverse otherwise. This holds on both slopes in center mode. A duty of 0 gives a constant inverse level, and a duty above the period gives a constant polarity level.
- R7: The working copies of period, duty, alignment and polarity reload from the `cfg_*` inputs only at a period boundary, or on every cycle while `en` is low. A change in the middle of a period has no effect until the next period starts.
- R8: While `en` is low, the counter is held at 0 counting up, `pwm_out` equals `!cfg_pol`, and `period_end` stays low.
- R9: After reset, the counter is 0 and `period_end` is low. All working copies are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable |
| src_tick | input | 13 | Advance strobes: 0 to 10 are prescaled master clock, 11 and 12 are the two dividers |
| cfg_sel | input | 4 | Strobe select |
| cfg_center | input | 1 | 1 selects center-aligned mode, 0 selects left-aligned mode |
| cfg_pol | input | 1 | Output level at period start |
| cfg_period | input | 16 | Period setting |
| cfg_duty | input | 16 | Duty (toggle) setting |
| pwm_out | output | 1 | Waveform pin |
| period_end | output | 1 | One-cycle end-of-period event |

## Verification
The assertions assume only that every input is synchronous to `clk`. They assume nothing about the strobe pattern or when the settings change. Their range and hold properties therefore have to survive select codes above 12, period values of 0 and 1, and settings rewritten in the middle of a period. The stimulus drives all inputs on the falling edge. It keeps period values small so that boundaries, turning points and enable toggles occur many times. It also mixes in out-of-range select codes and duty values beyond the period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  parameter int CNT_W = 16;
  parameter int NSRC  = 13;
  parameter int SEL_W = 4;

  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;

  // working copy of the channel settings
  typedef struct packed {
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] duty;
    logic             center;
    logic             pol;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_clk_sel.sv
module pwm_clk_sel
  import pwm_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int SW = SEL_W
) (
  input  logic [N-1:0]  src_tick,
  input  logic [SW-1:0] sel,
  output logic          tick
);
  logic [N-1:0] hit;

  generate
    for (genvar i = 0; i < N; i++) begin : g_src
      assign hit[i] = src_tick[i] && (sel == SW'(i));
    end
  endgenerate

  assign tick = |hit;

  // R1: at most one strobe source can be routed to the counter
  always_comb begin
    a_onehot_r1: assert ($onehot0(hit));
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  chan_cfg_t    cfg,
  output logic [W-1:0] cnt,
  output chan_cfg_t    act,
  output logic         evt
);
  localparam logic [W-1:0] ONE = W'(1);

  dir_e         dir, nxt_dir;
  logic [W-1:0] nxt_cnt;
  logic         bnd;

  always_comb begin
    bnd     = 1'b0;
    nxt_cnt = cnt + ONE;
    nxt_dir = DIR_UP;
    if (!act.center) begin
      bnd = (act.per <= ONE) || (cnt == act.per - ONE);
    end else if (dir == DIR_UP) begin
      if (cnt == act.per) begin
        bnd     = (act.per <= ONE);
        nxt_cnt = act.per - ONE;
        nxt_dir = DIR_DN;
      end
    end else begin
      bnd     = (cnt <= ONE);
      nxt_cnt = cnt - ONE;
      nxt_dir = DIR_DN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dir <= DIR_UP;
      act <= '0;
      evt <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      dir <= DIR_UP;
      act <= cfg;
      evt <= 1'b0;
    end else if (tick) begin
      if (bnd) begin
        cnt <= '0;
        dir <= DIR_UP;
        act <= cfg;
        evt <= 1'b1;
      end else begin
        cnt <= nxt_cnt;
        dir <= nxt_dir;
        evt <= 1'b0;
      end
    end else begin
      evt <= 1'b0;
    end
  end

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0) && !evt);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt) && !evt);

  p_left_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !act.center && act.per != '0) |-> (cnt < act.per));

  p_center_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act.center) |-> (cnt <= act.per));

  p_evt_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (cnt == '0) && (dir == DIR_UP));

  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(tick && bnd)) |=> $stable(act));
endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp
  import pwm_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         en,
  input  logic         idle_pol,
  input  logic [W-1:0] cnt,
  input  chan_cfg_t    act,
  output logic         wave
);
  logic below;

  assign below = (cnt < act.duty);

  always_comb begin
    if (!en) wave = !idle_pol;
    else     wave = below ? act.pol : !act.pol;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_center,
  input  logic             cfg_pol,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_duty,
  output logic             pwm_out,
  output logic             period_end
);
  logic             tick;
  logic [CNT_W-1:0] cnt;
  chan_cfg_t        cfg_in, act;

  assign cfg_in = '{per: cfg_period, duty: cfg_duty, center: cfg_center, pol: cfg_pol};

  pwm_clk_sel #(.N(NSRC), .SW(SEL_W)) u_sel (
    .src_tick (src_tick),
    .sel      (cfg_sel),
    .tick     (tick)
  );

  pwm_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .tick  (tick),
    .cfg   (cfg_in),
    .cnt   (cnt),
    .act   (act),
    .evt   (period_end)
  );

  pwm_cmp #(.W(CNT_W)) u_cmp (
    .en       (en),
    .idle_pol (cfg_pol),
    .cnt      (cnt),
    .act      (act),
    .wave     (pwm_out)
  );

  // R1: with an unused select code the channel never reports a boundary
  p_nosrc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel >= SEL_W'(NSRC)) |=> !period_end);
endmodule

// File: tb/pwm_chan_tb.sv
`timescale 1ns/1ps
module pwm_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [12:0] src = '1;
  logic [3:0]  sel = '0;
  logic        center = 1'b0;
  logic        pol = 1'b1;
  logic [15:0] per = '0;
  logic [15:0] duty = '0;
  logic        pwm_out, period_end;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bench model state
  logic [15:0] m_cnt, m_per, m_duty;
  logic        m_dn, m_ctr, m_pol, m_evt;

  always #2.5 clk = ~clk;

  pwm_chan u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .src_tick(src), .cfg_sel(sel),
    .cfg_center(center), .cfg_pol(pol), .cfg_period(per), .cfg_duty(duty),
    .pwm_out(pwm_out), .period_end(period_end)
  );

  function automatic logic exp_out();
    if (!en) return !pol;
    return (m_cnt < m_duty) ? m_pol : !m_pol;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_per = 0; m_duty = 0; m_dn = 0; m_ctr = 0; m_pol = 0; m_evt = 0;
  endtask

  task automatic load();
    m_per = per; m_duty = duty; m_ctr = center; m_pol = pol;
  endtask

  // next model state from the inputs that the coming rising edge will sample
  task automatic model_step();
    logic t, b;
    t = (sel < 4'd13) ? src[sel] : 1'b0;
    if (!en) begin
      m_cnt = 0; m_dn = 0; m_evt = 0; load();
    end else if (t) begin
      if (!m_ctr) b = (m_per <= 1) || (m_cnt == m_per - 16'd1);
      else if (!m_dn) b = (m_cnt == m_per) && (m_per <= 1);
      else b = (m_cnt <= 1);
      if (b) begin
        m_cnt = 0; m_dn = 0; m_evt = 1; load();
      end else begin
        m_evt = 0;
        if (!m_ctr) m_cnt = m_cnt + 1;
        else if (!m_dn && m_cnt == m_per) begin m_cnt = m_per - 1; m_dn = 1; end
        else if (!m_dn) m_cnt = m_cnt + 1;
        else m_cnt = m_cnt - 1;
      end
    end else begin
      m_evt = 0;
    end
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(tag, pwm_out, exp_out());
    chk("R5", period_end, m_evt);
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic setup(input logic c, input logic p, input logic [15:0] pr,
                       input logic [15:0] d, input logic [3:0] s);
    en = 0; center = c; pol = p; per = pr; duty = d; sel = s;
    cyc("R8");
    en = 1;
  endtask

  initial begin
    void'($urandom(32'hC0FFEE));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state, channel idle
    chk("R9", period_end, 1'b0);
    chk("R9", pwm_out, !pol);
    run("R8", 3);

    // R3: left aligned, P=4, duty 1
    setup(0, 1, 16'd4, 16'd1, 4'd0);
    run("R3", 12);
    // R3: P=0 gives event every strobe
    setup(0, 0, 16'd0, 16'd0, 4'd0);
    run("R3", 4);
    // R4: center aligned, P=3, duty 2
    setup(1, 1, 16'd3, 16'd2, 4'd0);
    run("R4", 14);
    setup(1, 0, 16'd1, 16'd1, 4'd0);
    run("R4", 6);
    // R7: settings change mid-period
    setup(0, 1, 16'd6, 16'd3, 4'd0);
    run("R7", 2);
    per = 16'd2; duty = 16'd1; center = 1; pol = 0;
    run("R7", 12);
    // R1: unused select code freezes counter
    setup(0, 1, 16'd3, 16'd1, 4'd14);
    run("R1", 6);
    // R1: divider strobe 12 only
    sel = 4'd12;
    for (int i = 0; i < 10; i++) begin
      src = {(i % 3 == 0), 12'h000};
      cyc("R1");
    end
    src = '1;
    // R6: duty extremes
    setup(0, 1, 16'd5, 16'd0, 4'd0);
    run("R6", 7);
    setup(1, 1, 16'd3, 16'd9, 4'd0);
    run("R6", 8);
    // R8: disable mid-period
    setup(0, 1, 16'd8, 16'd4, 4'd0);
    run("R8", 3);
    en = 0;
    run("R8", 4);

    // R2: random strobes, settings and enables
    en = 1;
    for (int i = 0; i < 4000; i++) begin
      src = {$urandom} % 14'h2000;
      src[0] = 1'b1;
      if ($urandom % 60 == 0) en = ~en;
      if ($urandom % 25 == 0) sel = ($urandom % 5 == 0) ? 4'($urandom % 16) : 4'($urandom % 13);
      if ($urandom % 10 == 0) per = 16'($urandom % 13);
      if ($urandom % 10 == 0) duty = 16'($urandom % 15);
      if ($urandom % 40 == 0) center = ~center;
      if ($urandom % 40 == 0) pol = ~pol;
      cyc("R2");
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule